// File: doc/BRIEF.md
# SWD Host Transfer Engine

This block carries out one complete serial-wire-debug transaction on behalf of a debug host: a single register read or register write aimed at either the debug port or an access port. The caller presents a port select, a direction bit, a two-bit register index and, for writes, a 32-bit value, then pulses `start`. The engine serialises the eight-bit request, releases the line for a turnaround, collects the target's three-bit response, and then either pushes the write word with its parity or gathers the read word and checks the parity the target sends back.

Each cycle of `clk` is one bit time on the wire. The bidirectional data pin is modelled as three signals: `swdio_out` and `swdio_oe` for the host's driver and `swdio_in` for what the pin carries. The target samples host bits on the rising edge, and the engine samples target bits on the rising edge. Retrying after a WAIT, clearing sticky errors and sequencing memory accesses are left to the logic above.

Top module: `swd_xfer_engine`

## Requirements
- R1: While idle (after reset and between transfers) the engine drives the line low (`swdio_oe`=1, `swdio_out`=0), with `busy`=0 and `done`=0.
- R2: The first eight bit times after an accepted `start` drive, in this order: 1 (start), port select, direction (1 = read), `reg_addr[0]`, `reg_addr[1]`, request parity (1 when the four preceding field bits hold an odd number of ones), 0 (stop), 1 (park). The engine drives all eight, including park.
- R3: After the request comes one turnaround bit time with `swdio_oe`=0. Then come three acknowledge bit times with `swdio_oe`=0, sampled first bit into `ack[0]`. The collected code is presented on `ack`. 3'b001 is OK, 3'b010 is WAIT, 3'b100 is FAULT.
- R4: For a write with OK, one more turnaround bit time (`swdio_oe`=0) follows. Then 32 driven data bits go out least significant first, then one driven parity bit that is 1 when the word holds an odd number of ones.
- R5: For a read with OK, 32 data bit times and one parity bit time follow with `swdio_oe`=0. The first data bit lands in `rd_data[0]`. One turnaround bit time with `swdio_oe`=0 follows the parity bit.
- R6: `par_err` is 1 after a read whose received parity bit differs from the odd-ones parity of the received word. It is 0 after a read with matching parity, and it is cleared when a new transfer is accepted.
- R7: Any acknowledge other than OK skips the data phase. Exactly one turnaround bit time (`swdio_oe`=0) follows the acknowledge, then the transfer ends.
- R8: `done` is high for exactly one cycle, right after the last bit time. An OK read or write lasts 46 bit times before `done`, and a non-OK one lasts 13. `busy` is high from the first request bit through the `done` cycle.
- R9: `start` and the request inputs are ignored while `busy` is high. A transfer in flight keeps the fields latched when it was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one wire bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer when idle |
| ap_sel | input | 1 | 1 selects an access port, 0 the debug port |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| reg_addr | input | 2 | Register index within the selected port |
| wr_data | input | 32 | Word to write |
| swdio_in | input | 1 | Level present on the data pin |
| swdio_out | output | 1 | Value the host drives |
| swdio_oe | output | 1 | Host driver enable |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| ack | output | 3 | Acknowledge code of the last transfer |
| rd_data | output | 32 | Word received by the last read |
| par_err | output | 1 | Parity mismatch on the last read |

## Verification
The bench acts as the target, bit by bit. It goes after the places where the framing of reads and writes differs. A design that puts the second turnaround on the wrong side would shift every write bit by one or drive into the target's parity slot. A design that reads the acknowledge in the wrong bit order would take WAIT (3'b010 stays the same either way) and confuse OK with FAULT. The bench also injects WAIT and FAULT to catch an engine that runs into the data phase anyway. It flips read parity to catch a checker that is stuck or inverted, and it wiggles `start` and the fields mid-transfer to catch a request that is latched too late.

// File: rtl/swd_xfer_pkg.sv
package swd_xfer_pkg;

    localparam int DATA_W = 32;
    localparam int ACK_W  = 3;
    localparam int HDR_W  = 8;
    localparam int CNT_W  = $clog2(DATA_W);

    localparam logic [ACK_W-1:0] ACK_OK    = 3'b001;
    localparam logic [ACK_W-1:0] ACK_WAIT  = 3'b010;
    localparam logic [ACK_W-1:0] ACK_FAULT = 3'b100;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HDR,
        ST_TRN_A,
        ST_ACK,
        ST_TRN_W,
        ST_WDATA,
        ST_WPAR,
        ST_RDATA,
        ST_RPAR,
        ST_TRN_END,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic       ap_sel;
        logic       rd_nwr;
        logic [1:0] addr;
    } swd_req_t;

    function automatic logic odd_ones(input logic [DATA_W-1:0] v);
        return ^v;
    endfunction

    // Bit 0 is sent first.
    function automatic logic [HDR_W-1:0] build_header(input swd_req_t r);
        logic p;
        p = r.ap_sel ^ r.rd_nwr ^ r.addr[0] ^ r.addr[1];
        return {1'b1, 1'b0, p, r.addr[1], r.addr[0], r.rd_nwr, r.ap_sel, 1'b1};
    endfunction

endpackage

// File: rtl/swd_seq_ctl.sv
module swd_seq_ctl
    import swd_xfer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             rd_nwr,
    input  logic             swdio_in,
    input  logic [ACK_W-1:0] ack_q,
    output seq_state_e       state_q
);
    seq_state_e       state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             rnw_q;
    logic [ACK_W-1:0] ack_full;

    assign ack_full = {swdio_in, ack_q[ACK_W-1:1]};

    always_comb begin
        state_d = state_q;
        cnt_d   = '0;
        unique case (state_q)
            ST_IDLE:    if (accept) state_d = ST_HDR;
            ST_HDR: begin
                if (cnt_q == CNT_W'(HDR_W-1)) state_d = ST_TRN_A;
                else cnt_d = cnt_q + 1'b1;
            end
            ST_TRN_A:   state_d = ST_ACK;
            ST_ACK: begin
                if (cnt_q == CNT_W'(ACK_W-1)) begin
                    if (ack_full != ACK_OK) state_d = ST_TRN_END;
                    else if (rnw_q)         state_d = ST_RDATA;
                    else                    state_d = ST_TRN_W;
                end else cnt_d = cnt_q + 1'b1;
            end
            ST_TRN_W:   state_d = ST_WDATA;
            ST_WDATA: begin
                if (cnt_q == CNT_W'(DATA_W-1)) state_d = ST_WPAR;
                else cnt_d = cnt_q + 1'b1;
            end
            ST_WPAR:    state_d = ST_DONE;
            ST_RDATA: begin
                if (cnt_q == CNT_W'(DATA_W-1)) state_d = ST_RPAR;
                else cnt_d = cnt_q + 1'b1;
            end
            ST_RPAR:    state_d = ST_TRN_END;
            ST_TRN_END: state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            rnw_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (accept) rnw_q <= rd_nwr;
        end
    end
endmodule

// File: rtl/swd_tx_path.sv
module swd_tx_path
    import swd_xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  swd_req_t          req,
    input  logic [DATA_W-1:0] wr_data,
    input  seq_state_e        state_q,
    output logic              swdio_out,
    output logic              swdio_oe
);
    logic [HDR_W-1:0]  hdr_sh;
    logic [DATA_W-1:0] dat_sh;
    logic              wpar_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_sh <= '0;
            dat_sh <= '0;
            wpar_q <= 1'b0;
        end else if (accept) begin
            hdr_sh <= build_header(req);
            dat_sh <= wr_data;
            wpar_q <= odd_ones(wr_data);
        end else if (state_q == ST_HDR) begin
            hdr_sh <= hdr_sh >> 1;
        end else if (state_q == ST_WDATA) begin
            dat_sh <= dat_sh >> 1;
        end
    end

    always_comb begin
        swdio_oe  = 1'b1;
        swdio_out = 1'b0;
        unique case (state_q)
            ST_HDR:   swdio_out = hdr_sh[0];
            ST_WDATA: swdio_out = dat_sh[0];
            ST_WPAR:  swdio_out = wpar_q;
            ST_TRN_A, ST_ACK, ST_TRN_W, ST_RDATA, ST_RPAR, ST_TRN_END:
                      swdio_oe  = 1'b0;
            default:  swdio_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/swd_rx_path.sv
module swd_rx_path
    import swd_xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  seq_state_e        state_q,
    input  logic              swdio_in,
    output logic [ACK_W-1:0]  ack_q,
    output logic [DATA_W-1:0] rd_q,
    output logic              perr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q  <= '0;
            rd_q   <= '0;
            perr_q <= 1'b0;
        end else if (accept) begin
            ack_q  <= '0;
            perr_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_ACK:   ack_q  <= {swdio_in, ack_q[ACK_W-1:1]};
                ST_RDATA: rd_q   <= {swdio_in, rd_q[DATA_W-1:1]};
                ST_RPAR:  perr_q <= swdio_in ^ odd_ones(rd_q);
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/swd_xfer_engine.sv
module swd_xfer_engine
    import swd_xfer_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        ap_sel,
    input  logic        rd_nwr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] wr_data,
    input  logic        swdio_in,
    output logic        swdio_out,
    output logic        swdio_oe,
    output logic        busy,
    output logic        done,
    output logic [2:0]  ack,
    output logic [31:0] rd_data,
    output logic        par_err
);
    seq_state_e state_q;
    swd_req_t   req;
    logic       accept;

    assign req    = '{ap_sel: ap_sel, rd_nwr: rd_nwr, addr: reg_addr};
    assign accept = start && (state_q == ST_IDLE);
    assign busy   = (state_q != ST_IDLE);
    assign done   = (state_q == ST_DONE);

    swd_seq_ctl u_ctl (
        .clk(clk), .rst(rst), .accept(accept), .rd_nwr(rd_nwr),
        .swdio_in(swdio_in), .ack_q(ack), .state_q(state_q)
    );

    swd_tx_path u_tx (
        .clk(clk), .rst(rst), .accept(accept), .req(req), .wr_data(wr_data),
        .state_q(state_q), .swdio_out(swdio_out), .swdio_oe(swdio_oe)
    );

    swd_rx_path u_rx (
        .clk(clk), .rst(rst), .accept(accept), .state_q(state_q),
        .swdio_in(swdio_in), .ack_q(ack), .rd_q(rd_data), .perr_q(par_err)
    );
endmodule

// File: rtl/swd_xfer_engine_chk.sv
module swd_xfer_engine_chk
    import swd_xfer_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       swdio_out,
    input logic       swdio_oe,
    input logic       busy,
    input logic       done,
    input logic       par_err,
    input seq_state_e state_q
);
    // R1
    idle_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (swdio_oe && !swdio_out));

    // R2
    start_bit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (swdio_oe && swdio_out));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R5
    read_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RDATA || state_q == ST_RPAR) |-> !swdio_oe);

    // R6
    perr_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(par_err) |-> ($past(state_q) == ST_RPAR));
endmodule

bind swd_xfer_engine swd_xfer_engine_chk u_chk (
    .clk(clk), .rst(rst), .swdio_out(swdio_out), .swdio_oe(swdio_oe),
    .busy(busy), .done(done), .par_err(par_err), .state_q(state_q)
);

// File: tb/swd_xfer_engine_tb_top.sv
module swd_xfer_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        ap_sel = 1'b0;
    logic        rd_nwr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] wr_data = '0;
    logic        swdio_in = 1'b1;
    logic        swdio_out, swdio_oe, busy, done, par_err;
    logic [2:0]  ack;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    swd_xfer_engine dut_i (
        .clk(clk), .rst(rst), .start(start), .ap_sel(ap_sel), .rd_nwr(rd_nwr),
        .reg_addr(reg_addr), .wr_data(wr_data), .swdio_in(swdio_in),
        .swdio_out(swdio_out), .swdio_oe(swdio_oe), .busy(busy), .done(done),
        .ack(ack), .rd_data(rd_data), .par_err(par_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_hdr(input logic ap, input logic rnw, input logic [1:0] a);
        logic [7:0] h;
        h[0] = 1'b1; h[1] = ap; h[2] = rnw; h[3] = a[0]; h[4] = a[1];
        h[5] = (32'(ap) + 32'(rnw) + 32'(a[0]) + 32'(a[1])) % 2 == 1;
        h[6] = 1'b0; h[7] = 1'b1;
        return h;
    endfunction

    function automatic logic odd_count(input logic [31:0] v);
        int c = 0;
        for (int i = 0; i < 32; i++) c += int'(v[i]);
        return (c % 2) == 1;
    endfunction

    task automatic host_line(input logic exp_oe, input logic exp_out, input string req);
        chk(swdio_oe === exp_oe, req, 32'(swdio_oe), 32'(exp_oe));
        if (exp_oe) chk(swdio_out === exp_out, req, 32'(swdio_out), 32'(exp_out));
    endtask

    task automatic run_xfer(input logic ap, input logic rnw, input logic [1:0] a,
                            input logic [31:0] wd, input logic [31:0] rdv,
                            input logic [2:0] ackv, input bit bad_par, input bit poke);
        logic [7:0] h;
        int bits;
        h = exp_hdr(ap, rnw, a);
        @(negedge clk);
        ap_sel = ap; rd_nwr = rnw; reg_addr = a; wr_data = wd; start = 1'b1;
        @(negedge clk);
        start = poke;
        if (poke) begin
            // R9: disturb the request fields while the transfer runs
            ap_sel = ~ap; rd_nwr = ~rnw; reg_addr = ~a; wr_data = ~wd;
        end
        chk(busy === 1'b1, "R8 busy at first bit", 32'(busy), 32'd1);
        bits = 0;
        for (int i = 0; i < 8; i++) begin
            swdio_in = 1'($urandom);
            host_line(1'b1, h[i], poke ? "R9 header under poke" : "R2 header bit");
            if (i == 6) start = 1'b0;
            @(negedge clk); bits++;
        end
        swdio_in = 1'b1;
        host_line(1'b0, 1'b0, "R3 turnaround after header");
        @(negedge clk); bits++;
        for (int i = 0; i < 3; i++) begin
            swdio_in = ackv[i];
            host_line(1'b0, 1'b0, "R3 ack released");
            @(negedge clk); bits++;
        end
        if (ackv == 3'b001 && !rnw) begin
            swdio_in = 1'b1;
            host_line(1'b0, 1'b0, "R4 write turnaround");
            @(negedge clk); bits++;
            for (int i = 0; i < 32; i++) begin
                swdio_in = 1'($urandom);
                host_line(1'b1, wd[i], poke ? "R9 write data under poke" : "R4 write data bit");
                @(negedge clk); bits++;
            end
            host_line(1'b1, odd_count(wd), "R4 write parity");
            @(negedge clk); bits++;
        end else if (ackv == 3'b001) begin
            for (int i = 0; i < 32; i++) begin
                swdio_in = rdv[i];
                host_line(1'b0, 1'b0, "R5 read data released");
                @(negedge clk); bits++;
            end
            swdio_in = odd_count(rdv) ^ bad_par;
            host_line(1'b0, 1'b0, "R5 read parity released");
            @(negedge clk); bits++;
            swdio_in = 1'b1;
            host_line(1'b0, 1'b0, "R5 read end turnaround");
            @(negedge clk); bits++;
        end else begin
            swdio_in = 1'b1;
            host_line(1'b0, 1'b0, "R7 turnaround after non-OK");
            @(negedge clk); bits++;
        end
        chk(done === 1'b1, "R8 done after last bit", 32'(done), 32'd1);
        chk(bits == ((ackv == 3'b001) ? 46 : 13), ackv == 3'b001 ? "R8 length" : "R7 length",
            32'(bits), (ackv == 3'b001) ? 32'd46 : 32'd13);
        chk(ack === ackv, "R3 ack code", 32'(ack), 32'(ackv));
        if (ackv == 3'b001 && rnw) begin
            chk(rd_data === rdv, "R5 read word", rd_data, rdv);
            chk(par_err === bad_par, "R6 parity flag", 32'(par_err), 32'(bad_par));
        end
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R8 done single cycle", {30'd0, done, busy}, 32'd0);
        host_line(1'b1, 1'b0, "R1 idle drive after transfer");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        int seed_init;
        seed_init = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy === 1'b0 && done === 1'b0, "R1 reset idle", {30'd0, busy, done}, 32'd0);
        host_line(1'b1, 1'b0, "R1 reset line drive");
        // directed corners
        run_xfer(1'b0, 1'b0, 2'b01, 32'hA5A5_0F0F, 32'h0, 3'b001, 1'b0, 1'b0);
        run_xfer(1'b1, 1'b1, 2'b11, 32'h0, 32'h8000_0001, 3'b001, 1'b0, 1'b0);
        run_xfer(1'b1, 1'b1, 2'b10, 32'h0, 32'h1234_5677, 3'b001, 1'b1, 1'b0);
        run_xfer(1'b0, 1'b1, 2'b00, 32'h0, 32'hFFFF_FFFF, 3'b001, 1'b0, 1'b0); // R6 clears
        run_xfer(1'b0, 1'b0, 2'b10, 32'hDEAD_BEEF, 32'h0, 3'b010, 1'b0, 1'b0); // R7 WAIT
        run_xfer(1'b1, 1'b1, 2'b01, 32'h0, 32'h5555_AAAA, 3'b100, 1'b0, 1'b0); // R7 FAULT
        run_xfer(1'b0, 1'b1, 2'b11, 32'h0, 32'h0, 3'b111, 1'b0, 1'b0);         // R7 no reply
        run_xfer(1'b1, 1'b0, 2'b00, 32'h0000_0001, 32'h0, 3'b001, 1'b0, 1'b1); // R9 poke
        // constrained random
        for (int n = 0; n < 40; n++) begin
            logic [2:0] av;
            int sel;
            sel = int'($urandom_range(0, 9));
            av = (sel < 6) ? 3'b001 : (sel < 8) ? 3'b010 : (sel < 9) ? 3'b100 : 3'b000;
            run_xfer(1'($urandom), 1'($urandom), 2'($urandom), $urandom, $urandom,
                     av, ($urandom_range(0, 3) == 0), ($urandom_range(0, 4) == 0));
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule